// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Status Flags

This block is the send side of an asynchronous serial port. A host loads bytes into a holding register, and the block serializes each byte onto a single output line. Each byte goes out as a low start bit, the data bits with the least significant bit first, and a high stop bit. Every bit lasts a fixed number of pulses of an external oversampling baud tick. Two status flags pace the host. The empty flag shows that the holding register can take a new byte. The end flag shows that the line has gone quiet with nothing left to send.

Turning the transmitter on does not send anything at once. The line first carries one full frame time of mark, and after that only bytes that the host has handed over are sent. The host hands over a byte in one of two ways. A processor read-then-clear handshake on the empty flag does it, and so does a write tagged as coming from a DMA engine, which clears the flag by itself. A byte handed over while a frame is on the line follows that frame with no idle gap. When the transmitter is off, a port data bit drives the output pin, so software can hold the line low to send a break.

Top module: `sertx_top`

## Requirements
- R1: A frame is one start bit at 0, DATA_W data bits sent least significant bit first, and one stop bit at 1. Each bit lasts OVS baud ticks (default 16 ticks, 8 data bits).
- R2: After the enable bit rises, txd_o stays at 1 for one full frame time (FRAME_BITS*OVS ticks). A byte handed over during that time stays in the holding register (empty_o stays 0) until the idle frame has ended.
- R3: With the transmitter enabled and no byte handed over, txd_o stays at 1 and tend_o stays at 1, however many ticks arrive.
- R4: A clear of the empty flag (empty_clr_i) takes effect only if the status was read (stat_rd_i) while empty_o was 1, in an earlier cycle since the flag was last set. Otherwise the clear is ignored.
- R5: A holding-register write with tdr_dma_i=1 stores the byte and clears empty_o without a read or a clear.
- R6: When a handed-over byte moves into the shift register, empty_o becomes 1 and tend_o becomes 0 on the same edge. A byte pending at the end of a stop bit starts its start bit on the very next tick period, with no gap.
- R7: tend_o becomes 1 on the edge at which the last stop bit ends, if no byte is pending then.
- R8: txi_o is 1 exactly when empty_o is 1 and the interrupt-enable bit (ctrl_ie_i, latched on ctrl_wr_i) is 1.
- R9: While the transmitter is disabled (tx_en_o=0), txd_o equals port_bit_i. With port_bit_i=0 this gives a break.
- R10: Clearing the enable bit, even in the middle of a frame, abandons the frame and forces empty_o=1 and tend_o=1.
- R11: After reset: tx_en_o=0, empty_o=1, tend_o=1, txi_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Oversampling baud tick, one-cycle pulse |
| ctrl_wr_i | input | 1 | Write strobe for the control bits |
| ctrl_en_i | input | 1 | Transmit-enable value to write |
| ctrl_ie_i | input | 1 | Interrupt-enable value to write |
| stat_rd_i | input | 1 | Status read strobe; arms the empty-flag clear |
| empty_clr_i | input | 1 | Request to clear the empty flag |
| tdr_wr_i | input | 1 | Holding-register write strobe |
| tdr_dma_i | input | 1 | Marks the write as a DMA write (clears the flag by itself) |
| tdr_data_i | input | DATA_W | Byte to write |
| port_bit_i | input | 1 | Port data bit that drives the pin while disabled |
| txd_o | output | 1 | Serial output pin |
| tx_en_o | output | 1 | Current transmit-enable bit |
| empty_o | output | 1 | Holding register empty flag |
| tend_o | output | 1 | Transmission-end flag |
| txi_o | output | 1 | Data-empty interrupt request |

## Verification
The bench decodes the line by counting baud ticks and sampling mid-bit. A shifter that sent MSB first or dropped the stop bit would decode to the wrong byte. A design that skipped the idle frame after enable would show a start bit during the first frame time. A design that moved a pending byte late would either leave a gap between frames or lose its tick alignment. Both would show up as wrong bits in the next frame. The bench sends a clear with no earlier read, and a design that accepted it would start a frame. It also checks the flags after a mid-frame disable and the held-low break level, so a design that left stale flags or kept driving the shifter output onto the pin would fail.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PRE  = 2'd1,
    ST_IDLE = 2'd2,
    ST_SEND = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_ie_i,
  input  logic              stat_rd_i,
  input  logic              empty_clr_i,
  input  logic              tdr_wr_i,
  input  logic              tdr_dma_i,
  input  logic [DATA_W-1:0] tdr_data_i,
  input  logic              load_i,
  input  logic              done_i,
  output logic              en_o,
  output logic              ie_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic [DATA_W-1:0] tdr_o
);
  logic en_q, ie_q, empty_q, tend_q, armed_q;
  logic [DATA_W-1:0] tdr_q;
  logic dma_wr, sw_clr;

  assign dma_wr = tdr_wr_i & tdr_dma_i;
  assign sw_clr = empty_clr_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      en_q <= ctrl_en_i;
      ie_q <= ctrl_ie_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tdr_q <= '0;
    else if (tdr_wr_i) tdr_q <= tdr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!en_q) begin
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (load_i) begin
      // byte moved to shifter: holding register free again
      empty_q <= 1'b1;
      tend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (done_i) tend_q <= 1'b1;
      if (dma_wr || sw_clr) begin
        empty_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (stat_rd_i && empty_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign en_o    = en_q;
  assign ie_o    = ie_q;
  assign empty_o = empty_q;
  assign tend_o  = tend_q;
  assign tdr_o   = tdr_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic              done_o,
  output logic              line_o
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int LAST       = FRAME_BITS - 1;
  localparam int OVS_W      = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  tx_state_e         state_q;
  logic [OVS_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic bit_end, last_bit, frame_last, is_data;

  assign bit_end    = tick_i && (cnt_q == OVS_W'(OVS - 1));
  assign last_bit   = (idx_q == IDX_W'(LAST));
  assign frame_last = (state_q == ST_SEND) && bit_end && last_bit;
  assign is_data    = (idx_q != '0) && !last_bit;
  assign load_o     = en_i && pending_i && ((state_q == ST_IDLE) || frame_last);
  assign done_o     = frame_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '1;
    end else if (!en_i) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '1;
    end else if (load_o) begin
      state_q <= ST_SEND;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= data_i;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q <= ST_PRE;
          cnt_q   <= '0;
          idx_q   <= '0;
        end
        ST_PRE, ST_SEND: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (last_bit) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_SEND && is_data) sh_q <= sh_q >> 1;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    line_o = 1'b1;
    if (state_q == ST_SEND) begin
      if (idx_q == '0)  line_o = 1'b0;
      else if (is_data) line_o = sh_q[0];
    end
  end
endmodule

// File: rtl/sertx_pinmux.sv
module sertx_pinmux (
  input  logic en_i,
  input  logic line_i,
  input  logic port_i,
  output logic pin_o
);
  assign pin_o = en_i ? line_i : port_i;
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_ie_i,
  input  logic              stat_rd_i,
  input  logic              empty_clr_i,
  input  logic              tdr_wr_i,
  input  logic              tdr_dma_i,
  input  logic [DATA_W-1:0] tdr_data_i,
  input  logic              port_bit_i,
  output logic              txd_o,
  output logic              tx_en_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic              txi_o
);
  logic en, ie, empty, tend, load, done, line;
  logic [DATA_W-1:0] tdr;

  sertx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_en_i, .ctrl_ie_i, .stat_rd_i,
    .empty_clr_i, .tdr_wr_i, .tdr_dma_i, .tdr_data_i,
    .load_i(load), .done_i(done),
    .en_o(en), .ie_o(ie), .empty_o(empty), .tend_o(tend), .tdr_o(tdr)
  );

  sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk_i, .rst_ni, .en_i(en), .tick_i(baud_tick_i),
    .pending_i(!empty), .data_i(tdr),
    .load_o(load), .done_o(done), .line_o(line)
  );

  sertx_pinmux u_mux (.en_i(en), .line_i(line), .port_i(port_bit_i), .pin_o(txd_o));

  assign tx_en_o = en;
  assign empty_o = empty;
  assign tend_o  = tend;
  assign txi_o   = empty & ie;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stat_rd_i,
  input logic empty_clr_i,
  input logic tdr_wr_i,
  input logic tdr_dma_i,
  input logic port_bit_i,
  input logic txd_o,
  input logic tx_en_o,
  input logic empty_o,
  input logic tend_o,
  input logic txi_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (!empty_o)  seen_q <= 1'b0;
    else if (stat_rd_i) seen_q <= 1'b1;
  end

  // R4 / R5: flag drops only after an armed clear or a DMA write
  a_r4_clear_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> ($past(tdr_wr_i && tdr_dma_i) || $past(empty_clr_i && seen_q)));

  a_r6_load_frees_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tend_o) |-> empty_o);

  a_r3_idle_is_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && empty_o && tend_o) |-> txd_o);

  a_r8_irq_only_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txi_o |-> empty_o);

  a_r10_disable_sets_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |=> (empty_o && tend_o));

  a_r9_port_drives_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (txd_o == port_bit_i));
endmodule

bind sertx_top sertx_chk u_chk (
  .clk_i, .rst_ni, .stat_rd_i, .empty_clr_i, .tdr_wr_i, .tdr_dma_i,
  .port_bit_i, .txd_o, .tx_en_o, .empty_o, .tend_o, .txi_o
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
  localparam int DW  = 8;
  localparam int OVS = 16;
  localparam int FRAME_TICKS = (DW + 2) * OVS;
  localparam int NVEC = 6;
  // bit 8 = hand over by DMA write, bits 7:0 = byte expected on the line
  localparam logic [8:0] VEC [NVEC] = '{9'h0A5, 9'h100, 9'h0FF, 9'h13C, 9'h081, 9'h15A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, ctrl_wr = 0, ctrl_en = 0, ctrl_ie = 0, stat_rd = 0, empty_clr = 0;
  logic tdr_wr = 0, tdr_dma = 0, port_bit = 1;
  logic [DW-1:0] tdr_data = '0;
  logic txd, tx_en, empty, tend, txi;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sertx_top #(.DATA_W(DW), .OVS(OVS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .ctrl_wr_i(ctrl_wr),
    .ctrl_en_i(ctrl_en), .ctrl_ie_i(ctrl_ie), .stat_rd_i(stat_rd),
    .empty_clr_i(empty_clr), .tdr_wr_i(tdr_wr), .tdr_dma_i(tdr_dma),
    .tdr_data_i(tdr_data), .port_bit_i(port_bit), .txd_o(txd),
    .tx_en_o(tx_en), .empty_o(empty), .tend_o(tend), .txi_o(txi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_ctrl(input logic en, input logic ie);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_en = en; ctrl_ie = ie;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic clr_empty();
    @(negedge clk); empty_clr = 1'b1;
    @(negedge clk); empty_clr = 1'b0;
  endtask

  task automatic wr_tdr(input logic [DW-1:0] d, input logic dma);
    @(negedge clk); tdr_wr = 1'b1; tdr_dma = dma; tdr_data = d;
    @(negedge clk); tdr_wr = 1'b0; tdr_dma = 1'b0;
  endtask

  task automatic hand_over(input logic [DW-1:0] d, input logic dma);
    if (dma) begin
      wr_tdr(d, 1'b1);
    end else begin
      rd_stat();
      wr_tdr(d, 1'b0);
      clr_empty();
    end
  endtask

  // decode one frame that has just started; optionally hand over the next byte mid-frame
  task automatic recv(input logic [DW-1:0] exp, input logic nxt_v,
                      input logic [DW-1:0] nxt_d, input logic nxt_dma);
    logic [DW-1:0] got = '0;
    for (int b = 0; b < DW + 2; b++) begin
      repeat (OVS / 2) do_tick();
      if (b == 0)            chk("R1 start bit", txd, 1'b0);
      else if (b == DW + 1)  chk("R1 stop bit", txd, 1'b1);
      else                   got[b-1] = txd;
      if (b == 3 && nxt_v) begin
        hand_over(nxt_d, nxt_dma);
        chk(nxt_dma ? "R5 dma write clears empty" : "R4 armed clear", empty, 1'b0);
      end
      repeat (OVS - OVS / 2) do_tick();
    end
    chk("R1 decoded byte", got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 tx_en", tx_en, 1'b0);
    chk("R11 empty", empty, 1'b1);
    chk("R11 tend", tend, 1'b1);
    chk("R11 txi", txi, 1'b0);
    chk("R9 pin follows port high", txd, 1'b1);
    port_bit = 1'b0;
    @(negedge clk);
    chk("R9 pin follows port low", txd, 1'b0);
    port_bit = 1'b1;

    set_ctrl(1'b1, 1'b1);
    @(negedge clk);
    chk("R8 txi with empty and ie", txi, 1'b1);
    // R4: clear with no prior read is ignored
    wr_tdr(VEC[0][7:0], 1'b0);
    clr_empty();
    @(negedge clk);
    chk("R4 unarmed clear ignored", empty, 1'b1);
    rd_stat();
    clr_empty();
    chk("R4 armed clear accepted", empty, 1'b0);
    chk("R8 txi drops", txi, 1'b0);

    // R2 idle frame of mark, byte held
    begin
      int bad = 0;
      for (int t = 0; t < FRAME_TICKS; t++) begin
        do_tick();
        if (txd !== 1'b1) bad++;
      end
      chk("R2 mark for one frame", bad, 0);
      chk("R2 byte still held", empty, 1'b0);
    end
    @(negedge clk);
    chk("R6 load sets empty", empty, 1'b1);
    chk("R6 load clears tend", tend, 1'b0);

    // table walk: back-to-back frames
    for (int i = 0; i < NVEC; i++) begin
      logic nv;
      nv = (i + 1 < NVEC);
      recv(VEC[i][7:0], nv, nv ? VEC[i+1][7:0] : 8'h00, nv ? VEC[i+1][8] : 1'b0);
      if (nv) begin
        chk("R6 no gap start bit", txd, 1'b0);
        chk("R6 tend stays 0", tend, 1'b0);
        chk("R6 empty set on load", empty, 1'b1);
      end
    end
    chk("R7 tend after last frame", tend, 1'b1);
    chk("R7 line idle", txd, 1'b1);

    // R3 enable alone sends nothing
    begin
      int bad = 0;
      for (int t = 0; t < 2 * FRAME_TICKS; t++) begin
        do_tick();
        if (txd !== 1'b1 || tend !== 1'b1) bad++;
      end
      chk("R3 idle with no data", bad, 0);
    end

    // R10 disable mid-frame, R9 break
    wr_tdr(8'h00, 1'b1);
    @(negedge clk);
    chk("R6 dma load start bit", txd, 1'b0);
    repeat (40) do_tick();
    chk("R6 tend 0 mid frame", tend, 1'b0);
    port_bit = 1'b0;
    set_ctrl(1'b0, 1'b0);
    @(negedge clk);
    chk("R9 break level", txd, 1'b0);
    chk("R10 empty forced", empty, 1'b1);
    chk("R10 tend forced", tend, 1'b1);
    repeat (20) do_tick();
    chk("R9 break held", txd, 1'b0);
    port_bit = 1'b1;
    @(negedge clk);
    chk("R9 break released", txd, 1'b1);

    // R2 again after re-enable, byte handed over by DMA during idle frame
    set_ctrl(1'b1, 1'b0);
    @(negedge clk);
    wr_tdr(8'hC3, 1'b1);
    chk("R5 dma clears empty", empty, 1'b0);
    begin
      int bad = 0;
      for (int t = 0; t < FRAME_TICKS; t++) begin
        do_tick();
        if (txd !== 1'b1) bad++;
      end
      chk("R2 mark after re-enable", bad, 0);
      chk("R2 byte held after re-enable", empty, 1'b0);
    end
    @(negedge clk);
    chk("R6 start after idle frame", txd, 1'b0);
    recv(8'hC3, 1'b0, 8'h00, 1'b0);
    chk("R7 tend after single frame", tend, 1'b1);
    chk("R8 txi off when ie 0", txi, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule